// File: doc/BRIEF.md
# Exception Fault Status and Escalation Unit

This block sits beside an exception-entry and exception-return sequencer. Each clock cycle the sequencer reports any access failure it met, tagged with the phase it occurred in: pushing the context frame, popping it on return, or reading the handler address from the vector table. It also reports a return token that was malformed or did not fit the processor state. The unit classifies the failure, records it in sticky status registers, and names the fault exception to raise. It also says whether that fault should preempt at once or be left pending.

Three status bytes record bus faults, memory-protection faults and usage faults. A 32-bit word records hard-fault causes. Software clears status bits by writing ones through dedicated clear inputs. When the specific handler for a fault is switched off, the fault escalates to the hard fault and a forced flag records that this happened. A failed vector read always becomes a hard fault. The result is registered and appears one cycle after the reported event. Priority values follow the usual convention: a numerically lower value is more urgent.

Top module: `fault_escalation_unit`

## Requirements
- R1: While reset is high and after reset, all outputs are zero: no valid fault, fault number 0, take-now 0, and all four status registers clear.
- R2: A bus error while pushing the frame sets bus status bit 4. A protection violation while pushing sets memory status bit 4. If both happen in the same cycle, the protection violation wins.
- R3: A bus error while popping the frame sets bus status bit 3. A protection violation while popping sets memory status bit 3. If both happen in the same cycle, the protection violation wins.
- R4: Any error during the vector read raises fault number 3 (hard) with take-now 1 and sets hard status bit 1. It does not set the forced bit (bit 30).
- R5: A bad return token with an invalid target address sets usage status bit 2. A bad return token with an invalid state sets usage status bit 1. When both are flagged, only bit 2 is set.
- R6: If the handler for the fault is enabled, the fault number is 5 for bus, 4 for memory and 6 for usage. Take-now is 1 only when that handler's priority value is strictly below the current priority value. Otherwise the fault is pended: valid is 1 and take-now is 0.
- R7: If the handler for a bus, memory or usage fault is disabled, the unit raises fault number 3 with take-now 1. It still sets the cause bit in that fault's own status byte and also sets hard status bit 30 (forced).
- R8: When several causes arrive in one cycle, precedence runs: vector read, then push, then pop, then return token. Only the winning cause updates any status register.
- R9: Status bits are sticky. A 1 on the matching clear input bit clears a bit, and a 0 leaves it alone. If a bit is set and cleared in the same cycle, it ends up set.
- R10: Outputs update one cycle after the event and valid is a single-cycle pulse. In a cycle with no event, valid is 0 and status changes only through the clear inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stk_bus_err_i | input | 1 | Bus error while pushing the context frame |
| stk_prot_err_i | input | 1 | Protection violation while pushing |
| unstk_bus_err_i | input | 1 | Bus error while popping the frame |
| unstk_prot_err_i | input | 1 | Protection violation while popping |
| vec_bus_err_i | input | 1 | Bus error on the vector-table read |
| vec_prot_err_i | input | 1 | Protection violation on the vector-table read |
| ret_bad_pc_i | input | 1 | Return token carries an invalid target |
| ret_bad_state_i | input | 1 | Return token mismatches processor state |
| bus_fault_en_i | input | 1 | Bus fault handler enabled |
| mem_fault_en_i | input | 1 | Memory-protection fault handler enabled |
| usage_fault_en_i | input | 1 | Usage fault handler enabled |
| bus_pri_i | input | PRI_W | Bus fault priority value |
| mem_pri_i | input | PRI_W | Memory fault priority value |
| usage_pri_i | input | PRI_W | Usage fault priority value |
| cur_pri_i | input | PRI_W | Current execution priority value |
| clr_bus_i | input | 8 | Write-one-to-clear mask, bus status |
| clr_mem_i | input | 8 | Write-one-to-clear mask, memory status |
| clr_usage_i | input | 8 | Write-one-to-clear mask, usage status |
| clr_hard_i | input | 32 | Write-one-to-clear mask, hard status |
| fault_valid_o | output | 1 | A fault decision is presented this cycle |
| fault_num_o | output | 4 | Selected fault exception number |
| take_now_o | output | 1 | 1 = preempt now, 0 = pend |
| bus_stat_o | output | 8 | Sticky bus fault status |
| mem_stat_o | output | 8 | Sticky memory fault status |
| usage_stat_o | output | 8 | Sticky usage fault status |
| hard_stat_o | output | 32 | Sticky hard fault status |

## Verification
The bench sweeps every combination of the eight cause inputs against every combination of enables, under four priority settings. The priority settings include a handler priority equal to the current priority. A comparator written with less-or-equal would then take a fault that should pend. A wrong precedence chain would record two causes, or the wrong one, when failures collide. Skipping the own-byte bit on escalation, or setting the forced bit on a vector-read fault, would show as a mismatch in the status registers. The clear masks are applied in the same cycles as the new events, so a design that lets clear beat set would lose a freshly recorded cause.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  localparam int STAT_W = 8;
  localparam int HARD_W = 32;
  localparam int NUM_W  = 4;

  localparam logic [NUM_W-1:0] EXC_HARD  = 4'd3;
  localparam logic [NUM_W-1:0] EXC_MEM   = 4'd4;
  localparam logic [NUM_W-1:0] EXC_BUS   = 4'd5;
  localparam logic [NUM_W-1:0] EXC_USAGE = 4'd6;

  localparam int BIT_PUSH      = 4;
  localparam int BIT_POP       = 3;
  localparam int BIT_BAD_PC    = 2;
  localparam int BIT_BAD_STATE = 1;
  localparam int BIT_VEC       = 1;
  localparam int BIT_FORCED    = 30;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_BUS, CLS_MEM, CLS_USAGE, CLS_VEC
  } fault_class_e;

  typedef struct packed {
    logic              valid;
    fault_class_e      cls;
    logic [STAT_W-1:0] bus_set;
    logic [STAT_W-1:0] mem_set;
    logic [STAT_W-1:0] use_set;
    logic [HARD_W-1:0] hard_set;
  } fault_cause_t;
endpackage

// File: rtl/fault_esc_classify.sv
module fault_esc_classify
  import fault_esc_pkg::*;
(
  input  logic         stk_bus,
  input  logic         stk_prot,
  input  logic         unstk_bus,
  input  logic         unstk_prot,
  input  logic         vec_bus,
  input  logic         vec_prot,
  input  logic         bad_pc,
  input  logic         bad_state,
  output fault_cause_t cause
);
  // Precedence: vector read, push, pop, return token.
  always_comb begin
    cause = '0;
    cause.cls = CLS_NONE;
    if (vec_bus || vec_prot) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_VEC;
      cause.hard_set[BIT_VEC] = 1'b1;
    end else if (stk_prot) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_MEM;
      cause.mem_set[BIT_PUSH] = 1'b1;
    end else if (stk_bus) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_BUS;
      cause.bus_set[BIT_PUSH] = 1'b1;
    end else if (unstk_prot) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_MEM;
      cause.mem_set[BIT_POP] = 1'b1;
    end else if (unstk_bus) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_BUS;
      cause.bus_set[BIT_POP] = 1'b1;
    end else if (bad_pc) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_USAGE;
      cause.use_set[BIT_BAD_PC] = 1'b1;
    end else if (bad_state) begin
      cause.valid = 1'b1;
      cause.cls   = CLS_USAGE;
      cause.use_set[BIT_BAD_STATE] = 1'b1;
    end
  end
endmodule

// File: rtl/fault_esc_route.sv
module fault_esc_route
  import fault_esc_pkg::*;
#(
  parameter int PRI_W = 3
) (
  input  logic             valid,
  input  fault_class_e     cls,
  input  logic             en_bus,
  input  logic             en_mem,
  input  logic             en_use,
  input  logic [PRI_W-1:0] pri_bus,
  input  logic [PRI_W-1:0] pri_mem,
  input  logic [PRI_W-1:0] pri_use,
  input  logic [PRI_W-1:0] pri_cur,
  output logic [NUM_W-1:0] num,
  output logic             take_now,
  output logic             forced
);
  logic             en_sel;
  logic [PRI_W-1:0] pri_sel;
  logic [NUM_W-1:0] num_sel;

  always_comb begin
    en_sel  = 1'b0;
    pri_sel = '0;
    num_sel = EXC_HARD;
    case (cls)
      CLS_BUS:   begin en_sel = en_bus; pri_sel = pri_bus; num_sel = EXC_BUS;   end
      CLS_MEM:   begin en_sel = en_mem; pri_sel = pri_mem; num_sel = EXC_MEM;   end
      CLS_USAGE: begin en_sel = en_use; pri_sel = pri_use; num_sel = EXC_USAGE; end
      default:   ;
    endcase
  end

  always_comb begin
    num      = '0;
    take_now = 1'b0;
    forced   = 1'b0;
    if (valid) begin
      if (cls == CLS_VEC) begin
        num      = EXC_HARD;
        take_now = 1'b1;
      end else if (!en_sel) begin
        num      = EXC_HARD;
        take_now = 1'b1;
        forced   = 1'b1;
      end else begin
        num      = num_sel;
        take_now = (pri_sel < pri_cur);
      end
    end
  end
endmodule

// File: rtl/fault_esc_sticky.sv
module fault_esc_sticky #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/fault_escalation_unit.sv
module fault_escalation_unit
  import fault_esc_pkg::*;
#(
  parameter int PRI_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stk_bus_err_i,
  input  logic              stk_prot_err_i,
  input  logic              unstk_bus_err_i,
  input  logic              unstk_prot_err_i,
  input  logic              vec_bus_err_i,
  input  logic              vec_prot_err_i,
  input  logic              ret_bad_pc_i,
  input  logic              ret_bad_state_i,
  input  logic              bus_fault_en_i,
  input  logic              mem_fault_en_i,
  input  logic              usage_fault_en_i,
  input  logic [PRI_W-1:0]  bus_pri_i,
  input  logic [PRI_W-1:0]  mem_pri_i,
  input  logic [PRI_W-1:0]  usage_pri_i,
  input  logic [PRI_W-1:0]  cur_pri_i,
  input  logic [7:0]        clr_bus_i,
  input  logic [7:0]        clr_mem_i,
  input  logic [7:0]        clr_usage_i,
  input  logic [31:0]       clr_hard_i,
  output logic              fault_valid_o,
  output logic [3:0]        fault_num_o,
  output logic              take_now_o,
  output logic [7:0]        bus_stat_o,
  output logic [7:0]        mem_stat_o,
  output logic [7:0]        usage_stat_o,
  output logic [31:0]       hard_stat_o
);
  localparam int N_BYTES = 3;

  fault_cause_t     cause;
  logic [NUM_W-1:0] route_num;
  logic             route_now;
  logic             route_forced;
  logic [HARD_W-1:0] hard_set;

  logic [N_BYTES-1:0][STAT_W-1:0] byte_set;
  logic [N_BYTES-1:0][STAT_W-1:0] byte_clr;
  logic [N_BYTES-1:0][STAT_W-1:0] byte_q;

  fault_esc_classify u_classify (
    .stk_bus    (stk_bus_err_i),
    .stk_prot   (stk_prot_err_i),
    .unstk_bus  (unstk_bus_err_i),
    .unstk_prot (unstk_prot_err_i),
    .vec_bus    (vec_bus_err_i),
    .vec_prot   (vec_prot_err_i),
    .bad_pc     (ret_bad_pc_i),
    .bad_state  (ret_bad_state_i),
    .cause      (cause)
  );

  fault_esc_route #(.PRI_W(PRI_W)) u_route (
    .valid    (cause.valid),
    .cls      (cause.cls),
    .en_bus   (bus_fault_en_i),
    .en_mem   (mem_fault_en_i),
    .en_use   (usage_fault_en_i),
    .pri_bus  (bus_pri_i),
    .pri_mem  (mem_pri_i),
    .pri_use  (usage_pri_i),
    .pri_cur  (cur_pri_i),
    .num      (route_num),
    .take_now (route_now),
    .forced   (route_forced)
  );

  always_comb begin
    hard_set = cause.hard_set;
    hard_set[BIT_FORCED] = cause.hard_set[BIT_FORCED] | route_forced;
  end

  assign byte_set[0] = cause.bus_set;
  assign byte_set[1] = cause.mem_set;
  assign byte_set[2] = cause.use_set;
  assign byte_clr[0] = clr_bus_i;
  assign byte_clr[1] = clr_mem_i;
  assign byte_clr[2] = clr_usage_i;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_stat
    fault_esc_sticky #(.W(STAT_W)) u_stat (
      .clk   (clk),
      .rst   (rst),
      .set_i (byte_set[g]),
      .clr_i (byte_clr[g]),
      .q_o   (byte_q[g])
    );
  end

  fault_esc_sticky #(.W(HARD_W)) u_hard (
    .clk   (clk),
    .rst   (rst),
    .set_i (hard_set),
    .clr_i (clr_hard_i),
    .q_o   (hard_stat_o)
  );

  assign bus_stat_o   = byte_q[0];
  assign mem_stat_o   = byte_q[1];
  assign usage_stat_o = byte_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid_o <= 1'b0;
      fault_num_o   <= '0;
      take_now_o    <= 1'b0;
    end else begin
      fault_valid_o <= cause.valid;
      fault_num_o   <= route_num;
      take_now_o    <= route_now;
    end
  end
endmodule

// File: rtl/fault_escalation_unit_chk.sv
module fault_escalation_unit_chk #(
  parameter int PRI_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              stk_bus_err_i,
  input logic              stk_prot_err_i,
  input logic              unstk_bus_err_i,
  input logic              unstk_prot_err_i,
  input logic              vec_bus_err_i,
  input logic              vec_prot_err_i,
  input logic              ret_bad_pc_i,
  input logic              ret_bad_state_i,
  input logic              bus_fault_en_i,
  input logic [7:0]        clr_bus_i,
  input logic [7:0]        clr_mem_i,
  input logic [7:0]        clr_usage_i,
  input logic [31:0]       clr_hard_i,
  input logic              fault_valid_o,
  input logic [3:0]        fault_num_o,
  input logic              take_now_o,
  input logic [7:0]        bus_stat_o,
  input logic [7:0]        mem_stat_o,
  input logic [7:0]        usage_stat_o,
  input logic [31:0]       hard_stat_o
);
  logic any_ev;
  logic vec_ev;
  assign vec_ev = vec_bus_err_i | vec_prot_err_i;
  assign any_ev = vec_ev | stk_bus_err_i | stk_prot_err_i | unstk_bus_err_i |
                  unstk_prot_err_i | ret_bad_pc_i | ret_bad_state_i;

  assert_vec_hard_R4: assert property (@(posedge clk) disable iff (rst)
    vec_ev |=> (fault_valid_o && fault_num_o == 4'd3 && take_now_o && hard_stat_o[1]));

  assert_escalate_forced_R7: assert property (@(posedge clk) disable iff (rst)
    (!vec_ev && stk_bus_err_i && !stk_prot_err_i && !bus_fault_en_i)
      |=> (fault_num_o == 4'd3 && take_now_o && hard_stat_o[30] && bus_stat_o[4]));

  assert_hard_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (fault_valid_o && fault_num_o == 4'd3) |-> take_now_o);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((($past(bus_stat_o) & ~$past(clr_bus_i)) & ~bus_stat_o) == 8'd0) &&
              ((($past(mem_stat_o) & ~$past(clr_mem_i)) & ~mem_stat_o) == 8'd0) &&
              ((($past(usage_stat_o) & ~$past(clr_usage_i)) & ~usage_stat_o) == 8'd0) &&
              ((($past(hard_stat_o) & ~$past(clr_hard_i)) & ~hard_stat_o) == 32'd0)));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !any_ev |=> !fault_valid_o);

  assert_pulse_src_R10: assert property (@(posedge clk) disable iff (rst)
    fault_valid_o |-> $past(any_ev));
endmodule

bind fault_escalation_unit fault_escalation_unit_chk #(.PRI_W(PRI_W)) chk_i (.*);

// File: tb/fault_escalation_unit_tb_top.sv
`timescale 1ns/1ps
module fault_escalation_unit_tb_top;
  localparam int  PRI_W  = 3;
  localparam time PERIOD = 20ns;
  localparam int  LIMIT  = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] ev = '0;
  logic [2:0] en = '0;
  logic [PRI_W-1:0] bus_pri = '0, mem_pri = '0, use_pri = '0, cur_pri = '0;
  logic [7:0]  clr_bus = '0, clr_mem = '0, clr_use = '0;
  logic [31:0] clr_hard = '0;
  logic        valid_o, now_o;
  logic [3:0]  num_o;
  logic [7:0]  bus_o, mem_o, use_o;
  logic [31:0] hard_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        exp_valid, exp_now;
  logic [3:0]  exp_num;
  logic [7:0]  exp_bus = '0, exp_mem = '0, exp_use = '0;
  logic [31:0] exp_hard = '0;
  string       tag;

  always #(PERIOD/2) clk = ~clk;

  fault_escalation_unit #(.PRI_W(PRI_W)) dut_i (
    .clk(clk), .rst(rst),
    .stk_bus_err_i(ev[0]), .stk_prot_err_i(ev[1]),
    .unstk_bus_err_i(ev[2]), .unstk_prot_err_i(ev[3]),
    .vec_bus_err_i(ev[4]), .vec_prot_err_i(ev[5]),
    .ret_bad_pc_i(ev[6]), .ret_bad_state_i(ev[7]),
    .bus_fault_en_i(en[0]), .mem_fault_en_i(en[1]), .usage_fault_en_i(en[2]),
    .bus_pri_i(bus_pri), .mem_pri_i(mem_pri), .usage_pri_i(use_pri), .cur_pri_i(cur_pri),
    .clr_bus_i(clr_bus), .clr_mem_i(clr_mem), .clr_usage_i(clr_use), .clr_hard_i(clr_hard),
    .fault_valid_o(valid_o), .fault_num_o(num_o), .take_now_o(now_o),
    .bus_stat_o(bus_o), .mem_stat_o(mem_o), .usage_stat_o(use_o), .hard_stat_o(hard_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements (R2..R9), applied to the model state.
  task automatic predict();
    logic [7:0]  sb = '0, sm = '0, su = '0;
    logic [31:0] sh = '0;
    int          kind = 0;  // 0 none, 1 bus, 2 mem, 3 usage, 4 vector
    logic        en_k = 1'b0;
    logic [PRI_W-1:0] p_k = '0;
    if (ev[4] | ev[5])  begin kind = 4; sh[1] = 1'b1; tag = "R4"; end   // R4, R8
    else if (ev[1])     begin kind = 2; sm[4] = 1'b1; tag = "R2"; end   // R2
    else if (ev[0])     begin kind = 1; sb[4] = 1'b1; tag = "R2"; end
    else if (ev[3])     begin kind = 2; sm[3] = 1'b1; tag = "R3"; end   // R3
    else if (ev[2])     begin kind = 1; sb[3] = 1'b1; tag = "R3"; end
    else if (ev[6])     begin kind = 3; su[2] = 1'b1; tag = "R5"; end   // R5
    else if (ev[7])     begin kind = 3; su[1] = 1'b1; tag = "R5"; end
    else                tag = "R10";
    case (kind)
      1: begin en_k = en[0]; p_k = bus_pri; exp_num = 4'd5; end
      2: begin en_k = en[1]; p_k = mem_pri; exp_num = 4'd4; end
      3: begin en_k = en[2]; p_k = use_pri; exp_num = 4'd6; end
      default: exp_num = (kind == 4) ? 4'd3 : 4'd0;
    endcase
    exp_valid = (kind != 0);
    exp_now   = 1'b0;
    if (kind == 4) exp_now = 1'b1;
    else if (kind != 0) begin
      if (!en_k) begin        // R7
        exp_num = 4'd3; exp_now = 1'b1; sh[30] = 1'b1; tag = "R7";
      end else begin          // R6: strict compare
        exp_now = (p_k < cur_pri);
        tag = "R6";
      end
    end
    // R9: set beats clear
    exp_bus  = (exp_bus  & ~clr_bus)  | sb;
    exp_mem  = (exp_mem  & ~clr_mem)  | sm;
    exp_use  = (exp_use  & ~clr_use)  | su;
    exp_hard = (exp_hard & ~clr_hard) | sh;
  endtask

  task automatic check_all();
    check(tag, "valid", {31'd0, valid_o}, {31'd0, exp_valid});
    check(tag, "num",   {28'd0, num_o},   {28'd0, exp_num});
    check(tag, "now",   {31'd0, now_o},   {31'd0, exp_now});
    check("R9", "bus_stat",   {24'd0, bus_o}, {24'd0, exp_bus});
    check("R9", "mem_stat",   {24'd0, mem_o}, {24'd0, exp_mem});
    check("R9", "usage_stat", {24'd0, use_o}, {24'd0, exp_use});
    check("R9", "hard_stat",  hard_o, exp_hard);
  endtask

  initial begin
    int idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "valid", {31'd0, valid_o}, 32'd0);
    check("R1", "num",   {28'd0, num_o},   32'd0);
    check("R1", "now",   {31'd0, now_o},   32'd0);
    check("R1", "stat",  {bus_o, mem_o, use_o, 8'd0} | hard_o, 32'd0);
    rst = 1'b0;
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 8; e++) begin
        for (int v = 0; v < 256; v++) begin
          bus_pri = PRI_W'(p * 2);
          mem_pri = PRI_W'(p + 1);
          use_pri = PRI_W'(7 - p);
          cur_pri = PRI_W'((p * 5) % 8);   // p=0 gives an equal-priority pend (R6)
          en = 3'(e);
          ev = 8'(v);
          clr_bus  = (idx % 5 == 0) ? 8'(idx * 29) : 8'd0;
          clr_mem  = (idx % 6 == 0) ? 8'(idx * 53) : 8'd0;
          clr_use  = (idx % 7 == 0) ? 8'(idx * 11) : 8'd0;
          clr_hard = (idx % 9 == 0) ? {16'(idx * 13), 16'(idx * 29)} | 32'h4000_0000 : 32'd0;
          predict();
          idx++;
          @(negedge clk);
          check_all();
        end
      end
    end
    // R10: quiet cycle, clears only
    ev = '0; clr_bus = 8'h10; clr_mem = '0; clr_use = '0; clr_hard = '0;
    predict();
    @(negedge clk);
    check_all();
    // R9: writing zeros leaves state alone
    clr_bus = '0;
    predict();
    @(negedge clk);
    check_all();
    // R9: full clear
    clr_bus = '1; clr_mem = '1; clr_use = '1; clr_hard = '1;
    predict();
    @(negedge clk);
    check_all();
    check("R9", "all_clear", {bus_o, mem_o, use_o, 8'd0} | hard_o, 32'd0);
    clr_bus = '0; clr_mem = '0; clr_use = '0; clr_hard = '0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule